// File: doc/BRIEF.md
# Half-Bridge Cycle-by-Cycle Overcurrent Limiter

This block sits between a PWM generator and the gate drivers of one half-bridge. In normal running it passes the PWM command through to the switches. The high-side enable follows the command. The low-side enable follows its complement. Two overcurrent flags, one for each switch, can take over the gates in either of two ways, and a mode input selects between them.

In cycle-by-cycle mode, a trip overrides the command for the rest of the current PWM period. The override depends on which switch tripped:
- A low-side trip turns both switches off.
- A high-side trip turns the high side off and forces the low side on.

A period-start strobe from the PWM generator releases the override. In latching mode, any trip turns both switches off and raises a shutdown request. The shutdown stays set until the bridge's own active-low reset input goes from low to high.

While the bridge reset input is low, both switches are held off. The mode input is captured only during that time. Every output is registered and updates on the clock edge that samples the stimulus.

Top module: `hb_trip_limiter`

## Requirements
- R1: With no override active, one cycle after sampling, gate_hi_o equals pwm_cmd_i and gate_lo_o equals the inverse of pwm_cmd_i.
- R2: In cycle-by-cycle mode (mode_latch_i captured as 0), a sampled oc_lo_i drives both gates low from the next cycle until the period-start strobe is sampled.
- R3: In cycle-by-cycle mode, a sampled oc_hi_i (with oc_lo_i low) drives gate_hi_o low and gate_lo_o high from the next cycle until the period-start strobe is sampled.
- R4: When oc_hi_i and oc_lo_i are sampled together in cycle-by-cycle mode, the low-side rule of R2 applies.
- R5: A sampled period_start_i ends the override, and the gates follow the PWM command from the same edge. If a trip is sampled in the same cycle as the strobe, the trip takes priority and starts a new override.
- R6: In latching mode (mode_latch_i captured as 1), either overcurrent flag sets shutdown_req_o and drives both gates low from the next cycle. No cycle-by-cycle override is applied in this mode.
- R7: A latched shutdown persists across period strobes, cleared flags and a low bridge reset. It clears only on the edge that samples bridge_rst_n high after it was sampled low.
- R8: While bridge_rst_n is sampled low, both gates are low from the next cycle, and overcurrent flags neither start an override nor set a shutdown.
- R9: mode_latch_i is captured only while bridge_rst_n is sampled low. Changes while it is high have no effect.
- R10: gate_hi_o and gate_lo_o are never high together.
- R11: After system reset (rst_n low), both gates and shutdown_req_o are low, and cycle-by-cycle mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bridge_rst_n | input | 1 | Active-low reset of this half-bridge; a rising edge clears a latched shutdown |
| mode_latch_i | input | 1 | 1 selects latching shutdown, 0 selects cycle-by-cycle limiting; captured while bridge_rst_n is low |
| pwm_cmd_i | input | 1 | PWM command, 1 requests the high-side switch |
| period_start_i | input | 1 | One-cycle strobe marking the start of a PWM period |
| oc_hi_i | input | 1 | High-side overcurrent flag |
| oc_lo_i | input | 1 | Low-side overcurrent flag |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| shutdown_req_o | output | 1 | Latched overcurrent shutdown request |

## Verification
In the default build, every result is due on the clock edge that samples the stimulus. This holds for gate following, trip overrides, release on the period strobe, shutdown set and clear, and forcing both gates off under bridge reset. The bench drives its inputs one time step after a rising edge and then waits for the next rising edge. It checks a step after that edge, so each check looks at exactly one cycle of latency. Overrides and latched shutdowns are checked again on later cycles while the PWM command toggles, which shows that they persist until their release event.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

  typedef enum logic [1:0] {
    OVR_NONE   = 2'd0,
    OVR_ALLOFF = 2'd1,
    OVR_LOWON  = 2'd2
  } ovr_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } gates_t;

  // Gate pattern for an override state and a PWM command.
  function automatic gates_t gate_drive(input ovr_t ovr, input logic pwm);
    gates_t g;
    case (ovr)
      OVR_ALLOFF: g = '{hi: 1'b0, lo: 1'b0};
      OVR_LOWON:  g = '{hi: 1'b0, lo: 1'b1};
      default:    g = '{hi: pwm,  lo: ~pwm};
    endcase
    return g;
  endfunction

  // Next override state in cycle-by-cycle mode; the low-side rule wins.
  function automatic ovr_t ovr_next(input ovr_t cur, input logic trip_lo,
                                    input logic trip_hi, input logic pstart);
    if (trip_lo)      return OVR_ALLOFF;
    else if (trip_hi) return OVR_LOWON;
    else if (pstart)  return OVR_NONE;
    else              return cur;
  endfunction

endpackage

// File: rtl/hbl_rst_front.sv
module hbl_rst_front #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_rst_n,
  input  logic mode_latch_i,
  output logic brst_ok,
  output logic rise_ev,
  output logic mode_q
);

  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign brst_ok = bridge_rst_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], bridge_rst_n};
      end
      assign brst_ok = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      prev_q <= brst_ok;
      if (!brst_ok) mode_q <= mode_latch_i;
    end
  end

  assign rise_ev = brst_ok & ~prev_q;

endmodule

// File: rtl/hbl_trip_fsm.sv
module hbl_trip_fsm
  import hbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic brst_ok,
  input  logic mode_q,
  input  logic oc_hi_i,
  input  logic oc_lo_i,
  input  logic period_start_i,
  output logic trip_lo_ev,
  output logic trip_hi_ev,
  output ovr_t ovr_d
);

  ovr_t ovr_q;

  assign trip_lo_ev = brst_ok & ~mode_q & oc_lo_i;
  assign trip_hi_ev = brst_ok & ~mode_q & oc_hi_i & ~oc_lo_i;

  always_comb begin
    if (!brst_ok || mode_q) ovr_d = OVR_NONE;
    else                    ovr_d = ovr_next(ovr_q, trip_lo_ev, trip_hi_ev, period_start_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= OVR_NONE;
    else        ovr_q <= ovr_d;
  end

endmodule

// File: rtl/hbl_shut_latch.sv
module hbl_shut_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic brst_ok,
  input  logic mode_q,
  input  logic rise_ev,
  input  logic oc_hi_i,
  input  logic oc_lo_i,
  output logic latch_ev,
  output logic shut_d,
  output logic shut_q
);

  assign latch_ev = brst_ok & mode_q & (oc_hi_i | oc_lo_i);
  assign shut_d   = (shut_q & ~rise_ev) | latch_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_q <= 1'b0;
    else        shut_q <= shut_d;
  end

endmodule

// File: rtl/hbl_gate_out.sv
module hbl_gate_out
  import hbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic brst_ok,
  input  logic shut_d,
  input  ovr_t ovr_d,
  input  logic pwm_cmd_i,
  output logic gate_hi_q,
  output logic gate_lo_q
);

  gates_t nxt;

  always_comb begin
    if (!brst_ok || shut_d) nxt = '{hi: 1'b0, lo: 1'b0};
    else                    nxt = gate_drive(ovr_d, pwm_cmd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
    end else begin
      gate_hi_q <= nxt.hi;
      gate_lo_q <= nxt.lo;
    end
  end

endmodule

// File: rtl/hb_trip_limiter.sv
module hb_trip_limiter
  import hbl_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_rst_n,
  input  logic mode_latch_i,
  input  logic pwm_cmd_i,
  input  logic period_start_i,
  input  logic oc_hi_i,
  input  logic oc_lo_i,
  output logic gate_hi_o,
  output logic gate_lo_o,
  output logic shutdown_req_o
);

  // Named internal events, also used by the bound checker.
  logic brst_ok;
  logic rise_ev;
  logic mode_q;
  logic trip_lo_ev;
  logic trip_hi_ev;
  logic latch_ev;
  logic shut_d;
  ovr_t ovr_d;

  hbl_rst_front #(.SYNC_STAGES(RST_SYNC_STAGES)) u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .bridge_rst_n (bridge_rst_n),
    .mode_latch_i (mode_latch_i),
    .brst_ok      (brst_ok),
    .rise_ev      (rise_ev),
    .mode_q       (mode_q)
  );

  hbl_trip_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .brst_ok        (brst_ok),
    .mode_q         (mode_q),
    .oc_hi_i        (oc_hi_i),
    .oc_lo_i        (oc_lo_i),
    .period_start_i (period_start_i),
    .trip_lo_ev     (trip_lo_ev),
    .trip_hi_ev     (trip_hi_ev),
    .ovr_d          (ovr_d)
  );

  hbl_shut_latch u_shut (
    .clk      (clk),
    .rst_n    (rst_n),
    .brst_ok  (brst_ok),
    .mode_q   (mode_q),
    .rise_ev  (rise_ev),
    .oc_hi_i  (oc_hi_i),
    .oc_lo_i  (oc_lo_i),
    .latch_ev (latch_ev),
    .shut_d   (shut_d),
    .shut_q   (shutdown_req_o)
  );

  hbl_gate_out u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .brst_ok   (brst_ok),
    .shut_d    (shut_d),
    .ovr_d     (ovr_d),
    .pwm_cmd_i (pwm_cmd_i),
    .gate_hi_q (gate_hi_o),
    .gate_lo_q (gate_lo_o)
  );

endmodule

// File: rtl/hbl_checks.sv
module hbl_checks (
  input logic clk,
  input logic rst_n,
  input logic brst_ok,
  input logic rise_ev,
  input logic mode_q,
  input logic trip_lo_ev,
  input logic trip_hi_ev,
  input logic latch_ev,
  input logic gate_hi,
  input logic gate_lo,
  input logic shut
);

  p_no_shoot_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  p_lo_trip_alloff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_lo_ev |=> (!gate_hi && !gate_lo));

  p_hi_trip_lowon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hi_ev |=> (!gate_hi && gate_lo));

  p_latch_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> (shut && !gate_hi && !gate_lo));

  p_shut_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && !rise_ev) |=> shut);

  p_bridge_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !brst_ok |=> (!gate_hi && !gate_lo));

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brst_ok |=> $stable(mode_q));

endmodule

bind hb_trip_limiter hbl_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brst_ok    (brst_ok),
  .rise_ev    (rise_ev),
  .mode_q     (mode_q),
  .trip_lo_ev (trip_lo_ev),
  .trip_hi_ev (trip_hi_ev),
  .latch_ev   (latch_ev),
  .gate_hi    (gate_hi_o),
  .gate_lo    (gate_lo_o),
  .shut       (shutdown_req_o)
);

// File: tb/sim_hb_trip_limiter.sv
module sim_hb_trip_limiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridge_rst_n = 1'b1;
  logic mode_latch_i = 1'b0;
  logic pwm_cmd_i = 1'b0;
  logic period_start_i = 1'b0;
  logic oc_hi_i = 1'b0;
  logic oc_lo_i = 1'b0;
  logic gate_hi_o, gate_lo_o, shutdown_req_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_trip_limiter u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .bridge_rst_n   (bridge_rst_n),
    .mode_latch_i   (mode_latch_i),
    .pwm_cmd_i      (pwm_cmd_i),
    .period_start_i (period_start_i),
    .oc_hi_i        (oc_hi_i),
    .oc_lo_i        (oc_lo_i),
    .gate_hi_o      (gate_hi_o),
    .gate_lo_o      (gate_lo_o),
    .shutdown_req_o (shutdown_req_o)
  );

  // One edge later, one time step past it: results due on that edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected outputs as {gate_hi, gate_lo, shutdown}.
  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {gate_hi_o, gate_lo_o, shutdown_req_o};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got hi/lo/sd=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input logic latch);
    bridge_rst_n = 1'b0;
    mode_latch_i = latch;
    tick();
    bridge_rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    tick();
    check("R11 reset", 3'b000);
    rst_n = 1'b1;
    tick();
    pwm_cmd_i = 1'b1;
    tick();
    check("R11 cbc default follows pwm", 3'b100);
  endtask

  task automatic t_normal();
    pwm_cmd_i = 1'b0; tick(); check("R1 pwm low", 3'b010);
    pwm_cmd_i = 1'b1; tick(); check("R1 pwm high", 3'b100);
    pwm_cmd_i = 1'b0; tick(); check("R1 pwm low again", 3'b010);
  endtask

  task automatic t_lo_trip();
    pwm_cmd_i = 1'b1;
    oc_lo_i = 1'b1; tick(); check("R2 lo trip", 3'b000);
    oc_lo_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pwm_cmd_i = ~pwm_cmd_i; tick(); check("R2 override held", 3'b000);
    end
    pwm_cmd_i = 1'b1; period_start_i = 1'b1; tick();
    check("R5 release after lo trip", 3'b100);
    period_start_i = 1'b0;
  endtask

  task automatic t_hi_trip();
    pwm_cmd_i = 1'b1;
    oc_hi_i = 1'b1; tick(); check("R3 hi trip", 3'b010);
    oc_hi_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pwm_cmd_i = ~pwm_cmd_i; tick(); check("R3 override held", 3'b010);
    end
    pwm_cmd_i = 1'b0; period_start_i = 1'b1; tick();
    check("R5 release after hi trip", 3'b010);
    period_start_i = 1'b0; pwm_cmd_i = 1'b1; tick();
    check("R1 following after release", 3'b100);
  endtask

  task automatic t_both();
    pwm_cmd_i = 1'b1;
    oc_hi_i = 1'b1; oc_lo_i = 1'b1; tick(); check("R4 both flags", 3'b000);
    oc_hi_i = 1'b0; oc_lo_i = 1'b0; tick(); check("R4 both held", 3'b000);
    period_start_i = 1'b1; tick(); check("R5 release after both", 3'b100);
    period_start_i = 1'b0;
  endtask

  task automatic t_collide();
    pwm_cmd_i = 1'b1;
    period_start_i = 1'b1; oc_hi_i = 1'b1; tick();
    check("R5 trip beats strobe", 3'b010);
    period_start_i = 1'b0; oc_hi_i = 1'b0; tick();
    check("R5 new override held", 3'b010);
    period_start_i = 1'b1; tick(); period_start_i = 1'b0;
    check("R5 released", 3'b100);
  endtask

  task automatic t_mode_ignored();
    mode_latch_i = 1'b1; tick(); tick();
    oc_lo_i = 1'b1; tick(); oc_lo_i = 1'b0;
    check("R9 mode change ignored, cbc used", 3'b000);
    tick(); check("R9 no shutdown set", 3'b000);
    period_start_i = 1'b1; tick(); period_start_i = 1'b0;
    check("R9 cbc release still works", 3'b100);
    mode_latch_i = 1'b0;
  endtask

  task automatic t_bridge_reset();
    pwm_cmd_i = 1'b1;
    bridge_rst_n = 1'b0; tick(); check("R8 bridge reset off", 3'b000);
    oc_hi_i = 1'b1; tick(); oc_hi_i = 1'b0;
    check("R8 oc ignored in reset", 3'b000);
    bridge_rst_n = 1'b1; tick();
    check("R8 no override after reset", 3'b100);
  endtask

  task automatic t_latch();
    set_mode(1'b1);
    pwm_cmd_i = 1'b1; tick(); check("R6 latch mode follows pwm", 3'b100);
    oc_hi_i = 1'b1; tick(); oc_hi_i = 1'b0;
    check("R6 hi trip latches", 3'b001);
    period_start_i = 1'b1; tick(); period_start_i = 1'b0;
    check("R7 strobe does not clear", 3'b001);
    tick(); check("R7 holds", 3'b001);
    bridge_rst_n = 1'b0; tick(); check("R7 holds in bridge reset", 3'b001);
    bridge_rst_n = 1'b1; tick(); check("R7 cleared on rising reset", 3'b100);
    oc_lo_i = 1'b1; tick(); oc_lo_i = 1'b0;
    check("R6 lo trip latches", 3'b001);
    pwm_cmd_i = 1'b0; tick(); check("R7 holds with pwm low", 3'b001);
    set_mode(1'b0);
    check("R9 back to cbc, shutdown cleared", 3'b010);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_normal();
    t_lo_trip();
    t_hi_trip();
    t_both();
    t_collide();
    t_mode_ignored();
    t_bridge_reset();
    t_latch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule